// File: doc/BRIEF.md
# Instruction Scheduler Stage Tracker

This block holds a fixed number of in-flight instruction slots and walks each occupied slot through four scheduling stages: waiting, pending, ready and executing. A dispatch port claims the lowest free slot and places the new instruction in a stage chosen from its operand flags. Three per-slot condition vectors move the slot forward: operand latency known, operands available and memory dependency satisfied. An issue port moves a chosen ready slot to executing. A write-back port releases an executing slot.

The stages are re-evaluated on every clock. A waiting slot whose operands and memory dependency are both satisfied goes straight to ready in one clock, and the event vectors then flag it as having entered both pending and ready. Each dispatch attempt gets a stall code that gives the reason for a refusal. A sticky flag records every refusal caused by a full resource. The choice of which ready slot to issue is made outside this block.

Top module: `sched_stage_tracker`

## Requirements
- R1: After reset no slot is valid, both event vectors are all zero, the token-stall flag is 0 and the direct-to-pending flag is 0.
- R2: The dispatch code is combinational and ignores `dispValid`. Its encoding is 0 available, 1 load queue full, 2 store queue full, 3 slot table full and 4 dispatch group stall. The first matching cause in this list wins: `loadQFull` with `dispIsLoad`, `storeQFull` with `dispIsStore`, all slots valid, then `groupStall`. `dispAccept` is `dispValid` with code 0. `dispIdx` is the lowest-numbered free slot.
- R3: A dispatched slot is placed by its flags. Stage codes in `stageVec[2*i+:2]` are 00 waiting, 01 pending, 10 ready and 11 executing. Latency unknown with operands unavailable gives waiting. Operands available with memory met gives ready. Every other combination gives pending.
- R4: A waiting slot moves to pending when its latency-known or operands-available bit is set. A slot with operands available but memory not met stays in pending.
- R5: A waiting or pending slot whose operands-available and memory-met bits are both set becomes ready at the next edge, even straight from waiting.
- R6: For one clock after a transition, `enteredPendVec[i]` flags a slot that left waiting (or was dispatched) into pending or ready. `enteredReadyVec[i]` flags a slot that became ready. Both can be set for the same slot.
- R7: An issue to a ready slot makes it executing. An issue to a slot that is not ready has no effect. An executing slot never changes stage again.
- R8: A write-back to an executing slot frees it. A write-back to any other slot has no effect.
- R9: `tokenStall` is set and stays set after any dispatch attempt refused with code 1, 2 or 3. A refusal with code 4 leaves it unchanged.
- R10: `dispToPend` is 1 for the clock after an accepted dispatch that landed in pending, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch attempt this cycle |
| dispLatKnown | input | 1 | New instruction: all operand latencies known |
| dispOpsAvail | input | 1 | New instruction: all register operands available |
| dispMemMet | input | 1 | New instruction: memory dependency satisfied |
| dispIsLoad | input | 1 | New instruction is a load |
| dispIsStore | input | 1 | New instruction is a store |
| loadQFull | input | 1 | Load queue has no room |
| storeQFull | input | 1 | Store queue has no room |
| groupStall | input | 1 | Dispatch group must stall |
| latKnownVec | input | NUM_ENTRIES | Per-slot latency known |
| opsAvailVec | input | NUM_ENTRIES | Per-slot operands available |
| memMetVec | input | NUM_ENTRIES | Per-slot memory dependency met |
| issueValid | input | 1 | Issue request |
| issueIdx | input | IDX_W | Slot to issue |
| wbValid | input | 1 | Write-back request |
| wbIdx | input | IDX_W | Slot to free |
| dispCode | output | 3 | Dispatch stall code |
| dispAccept | output | 1 | Dispatch taken this cycle |
| dispIdx | output | IDX_W | Slot a dispatch would take |
| validVec | output | NUM_ENTRIES | Slot occupied |
| stageVec | output | 2*NUM_ENTRIES | Stage code per slot |
| enteredPendVec | output | NUM_ENTRIES | Slot entered pending at last edge |
| enteredReadyVec | output | NUM_ENTRIES | Slot entered ready at last edge |
| tokenStall | output | 1 | Sticky resource-refusal flag |
| dispToPend | output | 1 | Last accepted dispatch landed in pending |

## Verification
All slot state is visible on `validVec` and `stageVec`. A wrong transition therefore shows at the ports one clock after the edge that caused it, and the event vectors show it in that same clock. A wrong allocation shows up at once: `dispIdx` points at an occupied slot, or the stage of an unrelated slot changes. A wrong code priority is seen combinationally on `dispCode` in the same cycle. A wrong sticky flag shows on the clock after a refused dispatch.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'b00,
    ST_PEND  = 2'b01,
    ST_READY = 2'b10,
    ST_EXEC  = 2'b11
  } stage_e;

  typedef enum logic [2:0] {
    DC_OK     = 3'd0,
    DC_LOADQ  = 3'd1,
    DC_STOREQ = 3'd2,
    DC_BUFS   = 3'd3,
    DC_GROUP  = 3'd4
  } dcode_e;

  localparam int STRB_IDX_W = 8;

  typedef struct packed {
    logic                  alloc;
    logic [STRB_IDX_W-1:0] allocIdx;
    stage_e                initStage;
    logic                  issue;
    logic [STRB_IDX_W-1:0] issueIdx;
    logic                  wb;
    logic [STRB_IDX_W-1:0] wbIdx;
  } strobe_t;

endpackage

// File: rtl/sst_ctrl.sv
module sst_ctrl
  import sst_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dispValid,
  input  logic                   dispLatKnown,
  input  logic                   dispOpsAvail,
  input  logic                   dispMemMet,
  input  logic                   dispIsLoad,
  input  logic                   dispIsStore,
  input  logic                   loadQFull,
  input  logic                   storeQFull,
  input  logic                   groupStall,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic                   issueValid,
  input  logic [IDX_W-1:0]       issueIdx,
  input  logic                   wbValid,
  input  logic [IDX_W-1:0]       wbIdx,
  output strobe_t                strb,
  output logic [2:0]             dispCode,
  output logic                   dispAccept,
  output logic [IDX_W-1:0]       dispIdx,
  output logic                   tokenStall,
  output logic                   dispToPend
);

  logic   tableFull;
  logic   [IDX_W-1:0] freeIdx;
  dcode_e code;
  stage_e initStage;

  assign tableFull = &validVec;

  // lowest free slot
  always_comb begin
    freeIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
    end
  end

  always_comb begin
    if (loadQFull && dispIsLoad)        code = DC_LOADQ;
    else if (storeQFull && dispIsStore) code = DC_STOREQ;
    else if (tableFull)                 code = DC_BUFS;
    else if (groupStall)                code = DC_GROUP;
    else                                code = DC_OK;
  end

  always_comb begin
    if (!dispLatKnown && !dispOpsAvail)  initStage = ST_WAIT;
    else if (dispOpsAvail && dispMemMet) initStage = ST_READY;
    else                                 initStage = ST_PEND;
  end

  assign dispCode   = code;
  assign dispAccept = dispValid && (code == DC_OK);
  assign dispIdx    = freeIdx;

  always_comb begin
    strb = '0;
    strb.alloc = dispAccept;
    strb.allocIdx[IDX_W-1:0] = freeIdx;
    strb.initStage = initStage;
    strb.issue = issueValid;
    strb.issueIdx[IDX_W-1:0] = issueIdx;
    strb.wb = wbValid;
    strb.wbIdx[IDX_W-1:0] = wbIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tokenStall <= 1'b0;
      dispToPend <= 1'b0;
    end else begin
      if (dispValid && (code == DC_LOADQ || code == DC_STOREQ || code == DC_BUFS))
        tokenStall <= 1'b1;
      dispToPend <= dispAccept && (initStage == ST_PEND);
    end
  end

  assert_no_accept_when_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    dispAccept |-> !tableFull);

  assert_token_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    tokenStall |=> tokenStall);

endmodule

// File: rtl/sst_table.sv
module sst_table
  import sst_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [NUM_ENTRIES-1:0]   latKnownVec,
  input  logic [NUM_ENTRIES-1:0]   opsAvailVec,
  input  logic [NUM_ENTRIES-1:0]   memMetVec,
  output logic [NUM_ENTRIES-1:0]   validVec,
  output logic [2*NUM_ENTRIES-1:0] stageVec,
  output logic [NUM_ENTRIES-1:0]   enteredPendVec,
  output logic [NUM_ENTRIES-1:0]   enteredReadyVec
);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    logic   validQ, validD, ePendQ, ePendD, eReadyQ, eReadyD;
    stage_e stageQ, stageD;
    logic   hitAlloc, hitIssue, hitWb, goReady;

    assign hitAlloc = strb.alloc && (strb.allocIdx == STRB_IDX_W'(i));
    assign hitIssue = strb.issue && (strb.issueIdx == STRB_IDX_W'(i));
    assign hitWb    = strb.wb && (strb.wbIdx == STRB_IDX_W'(i));
    assign goReady  = opsAvailVec[i] && memMetVec[i];

    always_comb begin
      validD  = validQ;
      stageD  = stageQ;
      ePendD  = 1'b0;
      eReadyD = 1'b0;
      if (hitAlloc) begin
        validD  = 1'b1;
        stageD  = strb.initStage;
        ePendD  = (strb.initStage != ST_WAIT);
        eReadyD = (strb.initStage == ST_READY);
      end else if (validQ) begin
        case (stageQ)
          ST_WAIT: if (latKnownVec[i] || opsAvailVec[i]) begin
            stageD  = goReady ? ST_READY : ST_PEND;
            ePendD  = 1'b1;
            eReadyD = goReady;
          end
          ST_PEND: if (goReady) begin
            stageD  = ST_READY;
            eReadyD = 1'b1;
          end
          ST_READY: if (hitIssue) stageD = ST_EXEC;
          default:  if (hitWb) validD = 1'b0;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ  <= 1'b0;
        stageQ  <= ST_WAIT;
        ePendQ  <= 1'b0;
        eReadyQ <= 1'b0;
      end else begin
        validQ  <= validD;
        stageQ  <= stageD;
        ePendQ  <= ePendD;
        eReadyQ <= eReadyD;
      end
    end

    assign validVec[i]         = validQ;
    assign stageVec[2*i +: 2]  = stageQ;
    assign enteredPendVec[i]   = ePendQ;
    assign enteredReadyVec[i]  = eReadyQ;

    assert_exec_never_demoted_R7: assert property (@(posedge clk) disable iff (!rstN)
      (validQ && stageQ == ST_EXEC && !hitWb) |=> (validQ && stageQ == ST_EXEC));

    assert_ready_event_matches_R6: assert property (@(posedge clk) disable iff (!rstN)
      eReadyQ |-> (validQ && stageQ == ST_READY));

    assert_pend_event_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
      ePendQ |-> (validQ && (stageQ == ST_PEND || stageQ == ST_READY)));
  end

  assert_alloc_free_slot_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.alloc |-> !validVec[strb.allocIdx[IDX_W-1:0]]);

endmodule

// File: rtl/sched_stage_tracker.sv
module sched_stage_tracker
  import sst_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     dispValid,
  input  logic                     dispLatKnown,
  input  logic                     dispOpsAvail,
  input  logic                     dispMemMet,
  input  logic                     dispIsLoad,
  input  logic                     dispIsStore,
  input  logic                     loadQFull,
  input  logic                     storeQFull,
  input  logic                     groupStall,
  input  logic [NUM_ENTRIES-1:0]   latKnownVec,
  input  logic [NUM_ENTRIES-1:0]   opsAvailVec,
  input  logic [NUM_ENTRIES-1:0]   memMetVec,
  input  logic                     issueValid,
  input  logic [IDX_W-1:0]         issueIdx,
  input  logic                     wbValid,
  input  logic [IDX_W-1:0]         wbIdx,
  output logic [2:0]               dispCode,
  output logic                     dispAccept,
  output logic [IDX_W-1:0]         dispIdx,
  output logic [NUM_ENTRIES-1:0]   validVec,
  output logic [2*NUM_ENTRIES-1:0] stageVec,
  output logic [NUM_ENTRIES-1:0]   enteredPendVec,
  output logic [NUM_ENTRIES-1:0]   enteredReadyVec,
  output logic                     tokenStall,
  output logic                     dispToPend
);

  strobe_t strb;

  sst_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .dispValid(dispValid), .dispLatKnown(dispLatKnown), .dispOpsAvail(dispOpsAvail),
    .dispMemMet(dispMemMet), .dispIsLoad(dispIsLoad), .dispIsStore(dispIsStore),
    .loadQFull(loadQFull), .storeQFull(storeQFull), .groupStall(groupStall),
    .validVec(validVec), .issueValid(issueValid), .issueIdx(issueIdx),
    .wbValid(wbValid), .wbIdx(wbIdx), .strb(strb), .dispCode(dispCode),
    .dispAccept(dispAccept), .dispIdx(dispIdx), .tokenStall(tokenStall),
    .dispToPend(dispToPend)
  );

  sst_table #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) table_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .latKnownVec(latKnownVec), .opsAvailVec(opsAvailVec), .memMetVec(memMetVec),
    .validVec(validVec), .stageVec(stageVec),
    .enteredPendVec(enteredPendVec), .enteredReadyVec(enteredReadyVec)
  );

endmodule

// File: tb/sched_stage_tracker_tb_top.sv
module sched_stage_tracker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rstN;
  logic dispValid, dispLatKnown, dispOpsAvail, dispMemMet, dispIsLoad, dispIsStore;
  logic loadQFull, storeQFull, groupStall;
  logic [N-1:0] latKnownVec, opsAvailVec, memMetVec;
  logic issueValid, wbValid;
  logic [IW-1:0] issueIdx, wbIdx;
  logic [2:0] dispCode;
  logic dispAccept;
  logic [IW-1:0] dispIdx;
  logic [N-1:0] validVec, enteredPendVec, enteredReadyVec;
  logic [2*N-1:0] stageVec;
  logic tokenStall, dispToPend;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sched_stage_tracker #(.NUM_ENTRIES(N)) dut_i (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispLatKnown(dispLatKnown),
    .dispOpsAvail(dispOpsAvail), .dispMemMet(dispMemMet), .dispIsLoad(dispIsLoad),
    .dispIsStore(dispIsStore), .loadQFull(loadQFull), .storeQFull(storeQFull),
    .groupStall(groupStall), .latKnownVec(latKnownVec), .opsAvailVec(opsAvailVec),
    .memMetVec(memMetVec), .issueValid(issueValid), .issueIdx(issueIdx),
    .wbValid(wbValid), .wbIdx(wbIdx), .dispCode(dispCode), .dispAccept(dispAccept),
    .dispIdx(dispIdx), .validVec(validVec), .stageVec(stageVec),
    .enteredPendVec(enteredPendVec), .enteredReadyVec(enteredReadyVec),
    .tokenStall(tokenStall), .dispToPend(dispToPend)
  );

  // {isLoad, isStore, loadQFull, storeQFull, groupStall, expected code[2:0]}
  localparam logic [7:0] CODE_TBL [8] = '{
    8'b10100_001, 8'b01010_010, 8'b10010_000, 8'b01100_000,
    8'b00001_100, 8'b10101_001, 8'b01011_010, 8'b00000_000
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] stg(input int i);
    return stageVec[2*i +: 2];
  endfunction

  task automatic idleIn();
    dispValid = 0; dispLatKnown = 0; dispOpsAvail = 0; dispMemMet = 0;
    dispIsLoad = 0; dispIsStore = 0; loadQFull = 0; storeQFull = 0; groupStall = 0;
    latKnownVec = '0; opsAvailVec = '0; memMetVec = '0;
    issueValid = 0; issueIdx = '0; wbValid = 0; wbIdx = '0;
  endtask

  task automatic dispatch(input logic lk, input logic oa, input logic mm);
    dispValid = 1; dispLatKnown = lk; dispOpsAvail = oa; dispMemMet = mm;
    tick();
    dispValid = 0; dispLatKnown = 0; dispOpsAvail = 0; dispMemMet = 0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    idleIn();
    rstN = 0;
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    chk("R1 valid", validVec, 0);
    chk("R1 pendEv", enteredPendVec, 0);
    chk("R1 readyEv", enteredReadyVec, 0);
    chk("R1 tokenStall", tokenStall, 0);
    chk("R1 dispToPend", dispToPend, 0);

    // R2 code priority table, empty slot table
    for (int v = 0; v < 8; v++) begin
      {dispIsLoad, dispIsStore, loadQFull, storeQFull, groupStall} = CODE_TBL[v][7:3];
      #1;
      chk("R2 code table", dispCode, CODE_TBL[v][2:0]);
    end
    idleIn();

    // R9 group stall refusal leaves token flag clear, nothing allocated
    groupStall = 1; dispValid = 1; #1;
    chk("R2 accept refused on group", dispAccept, 0);
    tick();
    idleIn();
    chk("R9 group no token", tokenStall, 0);
    chk("R2 no alloc", validVec, 0);

    // R3 initial placement
    chk("R2 first idx", dispIdx, 0);
    dispatch(0, 0, 0);
    chk("R3 wait valid", validVec, 4'b0001);
    chk("R3 wait stage", stg(0), 2'b00);
    chk("R6 no event on wait", enteredPendVec, 0);
    chk("R10 wait", dispToPend, 0);
    chk("R2 next idx", dispIdx, 1);
    dispatch(1, 0, 0);
    chk("R3 pend stage", stg(1), 2'b01);
    chk("R6 pend ev", enteredPendVec, 4'b0010);
    chk("R10 pend", dispToPend, 1);
    dispatch(0, 1, 1);
    chk("R3 ready stage", stg(2), 2'b10);
    chk("R6 both ev pend", enteredPendVec, 4'b0100);
    chk("R6 both ev ready", enteredReadyVec, 4'b0100);
    chk("R10 ready", dispToPend, 0);
    dispatch(0, 1, 0);
    chk("R3 mem hold", stg(3), 2'b01);
    chk("R10 memhold", dispToPend, 1);

    // R2/R9 full table
    dispValid = 1; #1;
    chk("R2 full code", dispCode, 3);
    chk("R2 full accept", dispAccept, 0);
    tick();
    dispValid = 0;
    chk("R9 token set", tokenStall, 1);
    chk("R10 cleared", dispToPend, 0);
    chk("R4 wait holds", stg(0), 2'b00);

    // R5 skip through pending in one edge
    latKnownVec[0] = 1; opsAvailVec[0] = 1; memMetVec[0] = 1;
    tick();
    idleIn();
    chk("R5 skip stage", stg(0), 2'b10);
    chk("R6 skip pend ev", enteredPendVec, 4'b0001);
    chk("R6 skip ready ev", enteredReadyVec, 4'b0001);

    // R4 memory dependency keeps slot pending
    opsAvailVec[3] = 1;
    tick();
    chk("R4 mem pending", stg(3), 2'b01);
    memMetVec[3] = 1;
    tick();
    idleIn();
    chk("R5 mem met", stg(3), 2'b10);
    chk("R6 ready only", enteredReadyVec, 4'b1000);
    chk("R6 no pend", enteredPendVec, 0);

    // R7 issue to non-ready ignored, then issue ready
    issueValid = 1; issueIdx = 1;
    tick();
    chk("R7 ignored issue", stg(1), 2'b01);
    issueIdx = 2;
    tick();
    idleIn();
    chk("R7 exec", stg(2), 2'b11);

    // R7 executing never promoted again
    latKnownVec = '1; opsAvailVec = '1; memMetVec = '1;
    tick();
    idleIn();
    chk("R7 exec stays", stg(2), 2'b11);
    chk("R5 pend to ready", stg(1), 2'b10);
    chk("R6 exec no event", enteredReadyVec[2], 0);

    // R8 write-back
    wbValid = 1; wbIdx = 0;
    tick();
    chk("R8 ignored wb", validVec, 4'b1111);
    wbIdx = 2;
    tick();
    idleIn();
    chk("R8 freed", validVec, 4'b1011);
    #1;
    chk("R2 reuse idx", dispIdx, 2);
    chk("R2 avail code", dispCode, 0);

    // single re-dispatch fills only slot 2, no slot taken twice
    dispatch(1, 0, 0);
    chk("R3 redispatch", validVec, 4'b1111);
    chk("R3 redispatch stage", stg(2), 2'b01);
    chk("R7 others intact", stg(0), 2'b10);
    repeat (3) tick();
    chk("R9 still sticky", tokenStall, 1);

    finishRun();
  end

endmodule